// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits next to a 32-bit processor core and decides, every cycle the core is not already being redirected, whether a pending synchronous exception, fast interrupt or normal interrupt is taken. Once a request is accepted, the block takes over from the core. It latches the request together with the core's program counter, status word and stack registers. It then runs the entry sequence and hands the core a complete set of new register values in a single update cycle.

Three entry paths exist. A fast interrupt parks the old PC and status in backup registers, jumps to a dedicated fast-vector address and raises the priority level to its maximum, with no memory traffic. A normal interrupt or an exception saves the status word and the PC on the interrupt stack through a word-wide load/store port with a ready handshake, then reads the handler address from memory. A normal interrupt reads from a relocatable table. An exception reads from a fixed table near the top of the address space, except for trap codes, which use the relocatable table. While the sequence runs, `busy` stalls the core. In the update cycle the block acknowledges interrupts to the controller, clears the taken pending flag and wakes the core from sleep.

Top module: `irq_entry_seq`

## Requirements
- R1: A normal request (`nrm_req`) is accepted only when status bit 16 (interrupt enable) is 1 and the level field, status bits 27:24, is strictly below `nrm_lvl`.
- R2: A fast request (`fst_req`) is accepted only when bit 16 is 1 and the level field is below 15. An exception request (`exc_req`) is always accepted. Among the requests that can be accepted, the exception wins over fast, and fast wins over normal.
- R3: If status bit 17 (user-stack select) is 1, the old R0 becomes the new user stack pointer and the interrupt stack pointer keeps its value. Otherwise the old R0 becomes the interrupt stack pointer. In the update cycle, `new_r0` equals `new_isp`.
- R4: In the update cycle, `new_sr` equals the status word captured at acceptance with bits 16, 17 and 20 (processor mode) cleared. Only the level field may change in addition.
- R5: Fast entry sets `bk_pc` to the old PC and `bk_sr` to the unmodified old status, with `bk_valid` high. `new_pc` is set to `fst_vec` and the level to 15. The fast path issues no memory request.
- R6: Normal and exception entry perform two writes. The first writes the unmodified status at ISP−4; the second writes the PC at ISP−8. The final interrupt stack pointer is ISP−8, where ISP is the stack pointer chosen under R3.
- R7: Normal entry reads `new_pc` from `tbl_base + 4*nrm_vec` and sets the level to the accepted `nrm_lvl`.
- R8: An exception with code below 0x100 reads its handler from 0xFFFFFFC0 + 4*code. Codes 0x100 to 0x1FF read from `tbl_base + 4*code[7:0]`. The level field is left unchanged. Named codes: 20 privilege, 21 access fault, 23 illegal opcode, 25 floating point, 30 non-maskable.
- R9: In the update cycle of an interrupt entry, `ack_valid` is high with `ack_vec` equal to `nrm_vec` as latched at acceptance and `ack_fast` marking the fast kind. Exactly one of `clr_nrm`/`clr_fst` pulses for the taken kind. Exception entry raises neither the acknowledge nor a clear.
- R10: `busy` is high from the cycle after acceptance through the update cycle. `upd_valid` and `clr_sleep` pulse together for one cycle at the end of every entry.
- R11: A memory request that is not yet answered by `mem_rdy` holds its address, direction and write data unchanged until it is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nrm_req | input | 1 | Normal interrupt pending |
| nrm_lvl | input | 4 | Level of the normal request |
| nrm_vec | input | 8 | Vector number of the normal request |
| fst_req | input | 1 | Fast interrupt pending |
| exc_req | input | 1 | Synchronous exception pending |
| exc_code | input | 9 | Exception code |
| cur_pc | input | 32 | Core program counter |
| cur_sr | input | 32 | Core status word |
| cur_r0 | input | 32 | Core active stack register |
| cur_usp | input | 32 | User stack pointer |
| cur_isp | input | 32 | Interrupt stack pointer |
| tbl_base | input | 32 | Relocatable vector table base |
| fst_vec | input | 32 | Fast interrupt handler address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes at this edge |
| busy | output | 1 | Entry in progress, core stalled |
| upd_valid | output | 1 | New register values valid this cycle |
| new_pc | output | 32 | Handler address |
| new_sr | output | 32 | New status word |
| new_r0 | output | 32 | New R0 |
| new_usp | output | 32 | New user stack pointer |
| new_isp | output | 32 | New interrupt stack pointer |
| bk_valid | output | 1 | Backup registers to be written |
| bk_pc | output | 32 | Backup PC |
| bk_sr | output | 32 | Backup status |
| ack_valid | output | 1 | Acknowledge to interrupt controller |
| ack_fast | output | 1 | Acknowledge is for the fast kind |
| ack_vec | output | 8 | Latched vector number |
| clr_nrm | output | 1 | Clear normal pending flag |
| clr_fst | output | 1 | Clear fast pending flag |
| clr_sleep | output | 1 | Clear sleep state |

## Verification
The bench targets the level comparison at equality, where a non-strict compare would take a request that must wait. It drives the fast request at level 14 and at level 15 to find an off-by-one in the fast threshold. It raises several requests at once to catch a wrong priority order. It runs stack selection with bit 17 both set and clear, where a swapped select would corrupt the user stack pointer or stack on the wrong pointer. It also checks the push order and offsets, the boundary between fixed-table codes and trap codes (0xFF, 0x100 and 0x1FF), and whether the status is saved before or after the mode bits are cleared. Random ready delays stretch every memory access, so a design that advanced without `mem_rdy` or changed its address mid-wait would store at the wrong place.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_PUSH_SR, ST_PUSH_PC, ST_FETCH, ST_DONE
  } ent_state_t;

  typedef enum logic [1:0] {K_NONE, K_EXC, K_FAST, K_NORM} ent_kind_t;

  // status word field positions
  localparam int SR_IE     = 16;
  localparam int SR_US     = 17;
  localparam int SR_PM     = 20;
  localparam int SR_LVL_LO = 24;

  // named synchronous exception codes
  localparam logic [8:0] EXC_PRIV   = 9'd20;
  localparam logic [8:0] EXC_ACCESS = 9'd21;
  localparam logic [8:0] EXC_ILLOP  = 9'd23;
  localparam logic [8:0] EXC_FLOAT  = 9'd25;
  localparam logic [8:0] EXC_NMI    = 9'd30;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_entry_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             idle,
  input  logic             sr_ie,
  input  logic [LVL_W-1:0] sr_lvl,
  input  logic             nrm_req,
  input  logic [LVL_W-1:0] nrm_lvl,
  input  logic             fst_req,
  input  logic             exc_req,
  output logic             take,
  output ent_kind_t        take_kind
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  function automatic logic lvl_below(input logic ie, input logic [LVL_W-1:0] cur,
                                     input logic [LVL_W-1:0] lim);
    return ie && (cur < lim);
  endfunction

  logic fast_ok, norm_ok;
  assign fast_ok = fst_req && lvl_below(sr_ie, sr_lvl, MAX_LVL);
  assign norm_ok = nrm_req && lvl_below(sr_ie, sr_lvl, nrm_lvl);

  always_comb begin
    if (exc_req)      take_kind = K_EXC;
    else if (fast_ok) take_kind = K_FAST;
    else if (norm_ok) take_kind = K_NORM;
    else              take_kind = K_NONE;
  end

  assign take = idle && (take_kind != K_NONE);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              LVL_W      = 4,
  parameter int              VEC_W      = 8,
  parameter int              CODE_W     = 9,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'hFFFF_FFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  ent_kind_t         take_kind,
  input  logic [VEC_W-1:0]  nrm_vec,
  input  logic [LVL_W-1:0]  nrm_lvl,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r0,
  input  logic [XLEN-1:0]   cur_usp,
  input  logic [XLEN-1:0]   cur_isp,
  input  logic [XLEN-1:0]   tbl_base,
  input  logic [XLEN-1:0]   fst_vec,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_rdy,
  output logic              idle,
  output logic              busy,
  output logic              upd_valid,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_r0,
  output logic [XLEN-1:0]   new_usp,
  output logic [XLEN-1:0]   new_isp,
  output logic              bk_valid,
  output logic [XLEN-1:0]   bk_pc,
  output logic [XLEN-1:0]   bk_sr,
  output logic              ack_valid,
  output logic              ack_fast,
  output logic [VEC_W-1:0]  ack_vec,
  output logic              clr_nrm,
  output logic              clr_fst,
  output logic              clr_sleep
);
  localparam logic [XLEN-1:0]  WSTEP   = XLEN'(4);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};
  localparam int               PAD_W   = XLEN - VEC_W - 2;

  function automatic logic [XLEN-1:0] tbl_slot(input logic [XLEN-1:0] base,
                                               input logic [VEC_W-1:0] idx);
    return base + {{PAD_W{1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] exc_slot(input logic [XLEN-1:0] base,
                                               input logic [CODE_W-1:0] code);
    if (code[CODE_W-1:VEC_W] == '0) return tbl_slot(FIXED_BASE, code[VEC_W-1:0]);
    else                            return tbl_slot(base, code[VEC_W-1:0]);
  endfunction

  ent_state_t        st;
  ent_kind_t         kind;
  logic [VEC_W-1:0]  l_vec;
  logic [LVL_W-1:0]  l_lvl;
  logic [CODE_W-1:0] l_code;
  logic [XLEN-1:0]   l_pc, l_sr, l_r0, l_usp, l_tbl, l_fvec, w_isp, r_pc, r_sr;
  logic [XLEN-1:0]   sr_next, vaddr;

  // status after entry: mode bits cleared, level per kind
  always_comb begin
    sr_next        = l_sr;
    sr_next[SR_IE] = 1'b0;
    sr_next[SR_US] = 1'b0;
    sr_next[SR_PM] = 1'b0;
    if (kind == K_FAST)      sr_next[SR_LVL_LO +: LVL_W] = MAX_LVL;
    else if (kind == K_NORM) sr_next[SR_LVL_LO +: LVL_W] = l_lvl;
  end

  assign vaddr = (kind == K_NORM) ? tbl_slot(l_tbl, l_vec) : exc_slot(l_tbl, l_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  kind <= K_NONE;
      l_vec <= '0;  l_lvl <= '0;  l_code <= '0;
      l_pc <= '0;  l_sr <= '0;  l_r0 <= '0;  l_usp <= '0;
      l_tbl <= '0;  l_fvec <= '0;  w_isp <= '0;  r_pc <= '0;  r_sr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          st <= ST_SAVE;  kind <= take_kind;
          l_vec <= nrm_vec;  l_lvl <= nrm_lvl;  l_code <= exc_code;
          l_pc <= cur_pc;  l_sr <= cur_sr;  l_r0 <= cur_r0;  l_usp <= cur_usp;
          l_tbl <= tbl_base;  l_fvec <= fst_vec;  w_isp <= cur_isp;
        end
        ST_SAVE: begin
          if (l_sr[SR_US]) l_usp <= l_r0;
          else             w_isp <= l_r0;
          r_sr <= sr_next;
          if (kind == K_FAST) begin
            r_pc <= l_fvec;
            st   <= ST_DONE;
          end else begin
            st <= ST_PUSH_SR;
          end
        end
        ST_PUSH_SR: if (mem_rdy) begin
          w_isp <= w_isp - WSTEP;
          st    <= ST_PUSH_PC;
        end
        ST_PUSH_PC: if (mem_rdy) begin
          w_isp <= w_isp - WSTEP;
          st    <= ST_FETCH;
        end
        ST_FETCH: if (mem_rdy) begin
          r_pc <= mem_rdata;
          st   <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_PUSH_SR) || (st == ST_PUSH_PC) || (st == ST_FETCH);
  assign mem_we    = (st == ST_PUSH_SR) || (st == ST_PUSH_PC);
  assign mem_addr  = (st == ST_FETCH) ? vaddr : (w_isp - WSTEP);
  assign mem_wdata = (st == ST_PUSH_SR) ? l_sr : ((st == ST_PUSH_PC) ? l_pc : '0);

  assign idle      = (st == ST_IDLE);
  assign busy      = !idle;
  assign upd_valid = (st == ST_DONE);
  assign new_pc    = r_pc;
  assign new_sr    = r_sr;
  assign new_r0    = w_isp;
  assign new_isp   = w_isp;
  assign new_usp   = l_usp;
  assign bk_valid  = upd_valid && (kind == K_FAST);
  assign bk_pc     = l_pc;
  assign bk_sr     = l_sr;
  assign clr_nrm   = upd_valid && (kind == K_NORM);
  assign clr_fst   = upd_valid && (kind == K_FAST);
  assign ack_valid = clr_nrm || clr_fst;
  assign ack_fast  = (kind == K_FAST);
  assign ack_vec   = l_vec;
  assign clr_sleep = upd_valid;

  // R11: an unanswered access holds still
  a_r11_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R5: the fast path never touches memory
  a_r5_fast_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind == K_FAST |-> !mem_req);
  // R6: the second push lands one word below the first
  a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_PUSH_PC && $past(st) == ST_PUSH_SR |-> mem_addr == $past(mem_addr) - WSTEP);
  // R4: mode bits are clear in every update
  a_r4_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !new_sr[SR_IE] && !new_sr[SR_US] && !new_sr[SR_PM]);
  // R9: acknowledge only with an update and a single clear
  a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> upd_valid && $onehot0({clr_nrm, clr_fst}) && (clr_nrm || clr_fst));
  // R10: update is a single-cycle pulse with the sleep clear
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> clr_sleep ##1 !upd_valid);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              LVL_W      = 4,
  parameter int              VEC_W      = 8,
  parameter int              CODE_W     = 9,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'hFFFF_FFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nrm_req,
  input  logic [LVL_W-1:0]  nrm_lvl,
  input  logic [VEC_W-1:0]  nrm_vec,
  input  logic              fst_req,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r0,
  input  logic [XLEN-1:0]   cur_usp,
  input  logic [XLEN-1:0]   cur_isp,
  input  logic [XLEN-1:0]   tbl_base,
  input  logic [XLEN-1:0]   fst_vec,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              upd_valid,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_r0,
  output logic [XLEN-1:0]   new_usp,
  output logic [XLEN-1:0]   new_isp,
  output logic              bk_valid,
  output logic [XLEN-1:0]   bk_pc,
  output logic [XLEN-1:0]   bk_sr,
  output logic              ack_valid,
  output logic              ack_fast,
  output logic [VEC_W-1:0]  ack_vec,
  output logic              clr_nrm,
  output logic              clr_fst,
  output logic              clr_sleep
);
  logic      idle, take;
  ent_kind_t take_kind;

  irq_accept #(.LVL_W(LVL_W)) u_accept (
    .idle      (idle),
    .sr_ie     (cur_sr[SR_IE]),
    .sr_lvl    (cur_sr[SR_LVL_LO +: LVL_W]),
    .nrm_req   (nrm_req),
    .nrm_lvl   (nrm_lvl),
    .fst_req   (fst_req),
    .exc_req   (exc_req),
    .take      (take),
    .take_kind (take_kind)
  );

  irq_entry_fsm #(
    .XLEN(XLEN), .LVL_W(LVL_W), .VEC_W(VEC_W), .CODE_W(CODE_W), .FIXED_BASE(FIXED_BASE)
  ) u_fsm (
    .clk, .rst_n, .take, .take_kind, .nrm_vec, .nrm_lvl, .exc_code,
    .cur_pc, .cur_sr, .cur_r0, .cur_usp, .cur_isp, .tbl_base, .fst_vec,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_rdy,
    .idle, .busy, .upd_valid, .new_pc, .new_sr, .new_r0, .new_usp, .new_isp,
    .bk_valid, .bk_pc, .bk_sr, .ack_valid, .ack_fast, .ack_vec,
    .clr_nrm, .clr_fst, .clr_sleep
  );

  // R1: an entry starts only from an exception or with interrupts enabled
  a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(exc_req) || $past(cur_sr[SR_IE]));
  // R2: an exception present at acceptance is the entry taken, so no acknowledge follows
  a_r2_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    take && exc_req |=> busy && !ack_valid);
endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  localparam logic [31:0] FIXB = 32'hFFFF_FFC0;
  localparam int K_NONE = 0, K_EXC = 1, K_FAST = 2, K_NORM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        nrm_req = 0, fst_req = 0, exc_req = 0, mem_rdy = 0;
  logic [3:0]  nrm_lvl = 0;
  logic [7:0]  nrm_vec = 0;
  logic [8:0]  exc_code = 0;
  logic [31:0] cur_pc = 0, cur_sr = 0, cur_r0 = 0, cur_usp = 0, cur_isp = 0;
  logic [31:0] tbl_base = 0, fst_vec = 0, mem_rdata = 0;
  logic        mem_req, mem_we, busy, upd_valid, bk_valid, ack_valid, ack_fast;
  logic        clr_nrm, clr_fst, clr_sleep;
  logic [31:0] mem_addr, mem_wdata, new_pc, new_sr, new_r0, new_usp, new_isp, bk_pc, bk_sr;
  logic [7:0]  ack_vec;

  irq_entry_seq u_dut (.*);

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] clr_mode(input logic [31:0] s);
    return s & ~32'h0013_0000;
  endfunction

  function automatic logic [31:0] set_lvl(input logic [31:0] s, input logic [3:0] l);
    return {s[31:28], l, s[23:0]};
  endfunction

  function automatic int pick(input logic [31:0] s, input bit e, input bit f, input bit n,
                              input logic [3:0] nl);
    if (e) return K_EXC;
    if (f && s[16] && s[27:24] < 4'd15) return K_FAST;
    if (n && s[16] && s[27:24] < nl) return K_NORM;
    return K_NONE;
  endfunction

  function automatic logic [31:0] handler_addr(input int k, input logic [31:0] tb,
                                               input logic [7:0] v, input logic [8:0] c);
    if (k == K_NORM) return tb + 32'(v) * 4;
    if (c < 9'h100)  return FIXB + 32'(c) * 4;
    return tb + 32'(c - 9'h100) * 4;
  endfunction

  task automatic trial(input string tag, input logic [31:0] sr, input bit e, input bit f,
                       input bit n, input logic [3:0] nl, input logic [7:0] nv, input logic [8:0] code);
    int k;
    int nwr;
    bit got;
    logic [31:0] wa[2], wd[2];
    logic [31:0] pc0, r00, usp0, isp0, tb0, fv0, sisp, susp, ea;
    logic [31:0] g_pc, g_sr, g_r0, g_usp, g_isp, g_bpc, g_bsr;
    logic g_bk, g_ack, g_af, g_cn, g_cf, g_cs;
    logic [7:0] g_av;
    k = pick(sr, e, f, n, nl);
    @(negedge clk);
    pc0 = $urandom & ~32'h3;  r00 = $urandom & ~32'h3;  usp0 = $urandom & ~32'h3;
    isp0 = $urandom & ~32'h3; tb0 = $urandom & ~32'h3FF; fv0 = $urandom & ~32'h3;
    cur_pc = pc0; cur_sr = sr; cur_r0 = r00; cur_usp = usp0; cur_isp = isp0;
    tbl_base = tb0; fst_vec = fv0;
    nrm_lvl = nl; nrm_vec = nv; exc_code = code;
    exc_req = e; fst_req = f; nrm_req = n;
    nwr = 0; got = 0; mem_rdy = 0;
    g_pc = 0; g_sr = 0; g_r0 = 0; g_usp = 0; g_isp = 0; g_bpc = 0; g_bsr = 0;
    g_bk = 0; g_ack = 0; g_af = 0; g_cn = 0; g_cf = 0; g_cs = 0; g_av = 0;
    if (k == K_NONE) begin
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (busy) got = 1;
      end
      chk(!got, {tag, " R1/R2 rejected request starts no entry"}, 32'(got), 0);
      exc_req = 0; fst_req = 0; nrm_req = 0;
      return;
    end
    for (int c = 0; c < 80 && !got; c++) begin
      @(negedge clk);
      if (upd_valid) begin
        got = 1;
        g_pc = new_pc; g_sr = new_sr; g_r0 = new_r0; g_usp = new_usp; g_isp = new_isp;
        g_bk = bk_valid; g_bpc = bk_pc; g_bsr = bk_sr; g_ack = ack_valid; g_af = ack_fast;
        g_av = ack_vec; g_cn = clr_nrm; g_cf = clr_fst; g_cs = clr_sleep;
        mem_rdy = 0;
      end else if (mem_req) begin
        mem_rdy = ($urandom % 3) == 0;
        mem_rdata = rd_word(mem_addr);
        if (mem_rdy && mem_we) begin
          if (nwr < 2) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; end
          nwr++;
        end
      end else begin
        mem_rdy = 0;
      end
    end
    exc_req = 0; fst_req = 0; nrm_req = 0;
    chk(got, {tag, " R10 entry completes with update pulse"}, 32'(got), 1);
    if (!got) return;
    chk(g_cs, {tag, " R10 sleep clear with update"}, 32'(g_cs), 1);
    sisp = sr[17] ? isp0 : r00;
    susp = sr[17] ? r00 : usp0;
    chk(g_usp == susp, {tag, " R3 user stack pointer"}, g_usp, susp);
    chk(g_r0 == g_isp, {tag, " R3 r0 equals isp"}, g_r0, g_isp);
    if (k == K_FAST) begin
      chk(nwr == 0, {tag, " R5 no memory writes"}, 32'(nwr), 0);
      chk(g_pc == fv0, {tag, " R5 pc from fast vector"}, g_pc, fv0);
      chk(g_bk && g_bpc == pc0, {tag, " R5 backup pc"}, g_bpc, pc0);
      chk(g_bsr == sr, {tag, " R5 backup status unmodified"}, g_bsr, sr);
      chk(g_isp == sisp, {tag, " R3 isp on fast path"}, g_isp, sisp);
      chk(g_sr == set_lvl(clr_mode(sr), 4'd15), {tag, " R4 R5 new status"}, g_sr,
          set_lvl(clr_mode(sr), 4'd15));
      chk(g_ack && g_af && g_av == nv && g_cf && !g_cn, {tag, " R9 fast acknowledge"},
          {g_ack, g_af, g_cf, g_cn, 20'h0, g_av}, {4'b1110, 20'h0, nv});
    end else begin
      chk(nwr == 2, {tag, " R6 two pushes"}, 32'(nwr), 2);
      if (nwr == 2) begin
        chk(wa[0] == sisp - 4 && wd[0] == sr, {tag, " R6 status push"}, wa[0], sisp - 4);
        chk(wa[1] == sisp - 8 && wd[1] == pc0, {tag, " R6 pc push"}, wa[1], sisp - 8);
      end
      chk(g_isp == sisp - 8, {tag, " R6 final isp"}, g_isp, sisp - 8);
      chk(!g_bk, {tag, " R5 no backup write"}, 32'(g_bk), 0);
      ea = rd_word(handler_addr(k, tb0, nv, code));
      if (k == K_NORM) begin
        chk(g_pc == ea, {tag, " R7 handler from table"}, g_pc, ea);
        chk(g_sr == set_lvl(clr_mode(sr), nl), {tag, " R4 R7 new status level"}, g_sr,
            set_lvl(clr_mode(sr), nl));
        chk(g_ack && !g_af && g_av == nv && g_cn && !g_cf, {tag, " R9 normal acknowledge"},
            {g_ack, g_af, g_cf, g_cn, 20'h0, g_av}, {4'b1001, 20'h0, nv});
      end else begin
        chk(g_pc == ea, {tag, " R8 exception handler"}, g_pc, ea);
        chk(g_sr == clr_mode(sr), {tag, " R4 R8 status keeps level"}, g_sr, clr_mode(sr));
        chk(!g_ack && !g_cn && !g_cf, {tag, " R9 no acknowledge on exception"},
            {29'h0, g_ack, g_cn, g_cf}, 0);
      end
    end
    @(negedge clk);
    chk(!busy, {tag, " R10 busy drops after update"}, 32'(busy), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !upd_valid && !ack_valid, "R10 reset state idle",
        {28'h0, busy, mem_req, upd_valid, ack_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // directed corner cases
    trial("eq_lvl",   32'h0501_0000, 0, 0, 1, 4'd5, 8'h11, 0);      // R1 equal level rejected
    trial("ie_off",   32'h0000_0000, 0, 1, 1, 4'd9, 8'h12, 0);      // R1 R2 disabled
    trial("lvl_up",   32'h0501_0000, 0, 0, 1, 4'd6, 8'h13, 0);      // R1 R7 one above
    trial("fast14",   32'h0E13_0000, 0, 1, 0, 4'd0, 8'h14, 0);      // R2 R5 level 14
    trial("fast15",   32'h0F01_0000, 0, 1, 1, 4'd15, 8'h15, 0);     // R2 level 15 rejected
    trial("fast_win", 32'h0011_0000, 0, 1, 1, 4'd7, 8'h16, 0);      // R2 fast over normal
    trial("exc_win",  32'h0001_0000, 1, 1, 1, 4'd7, 8'h17, 9'd23);  // R2 exception first
    trial("exc_ieoff",32'h0310_0000, 1, 0, 0, 4'd0, 8'h18, 9'd30);  // R2 R8 exception always
    trial("exc_ff",   32'h0002_0000, 1, 0, 0, 4'd0, 8'h00, 9'h0FF); // R8 top fixed slot
    trial("trap_lo",  32'h0002_0000, 1, 0, 0, 4'd0, 8'h00, 9'h100); // R8 trap boundary
    trial("trap_hi",  32'h0000_0000, 1, 0, 0, 4'd0, 8'h00, 9'h1FF); // R8 last trap
    trial("us_norm",  32'h0133_0000, 0, 0, 1, 4'd2, 8'hFF, 0);      // R3 user stack select
    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic [31:0] s;
      logic [8:0]  cd;
      s = $urandom;
      if (($urandom % 4) != 0) s[16] = 1'b1;
      case ($urandom % 7)
        0: cd = 9'd20; 1: cd = 9'd21; 2: cd = 9'd25; 3: cd = 9'd30;
        4: cd = 9'h100 | 9'($urandom % 256);
        default: cd = 9'($urandom % 256);
      endcase
      trial("rand", s, ($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
            4'($urandom), 8'($urandom), cd);
    end
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule